// File: doc/BRIEF.md
# SDRAM Command and Mask Decoder

This block sits on the device side of a single-data-rate SDRAM command bus. On every rising clock edge it samples chip select, the three active-low row/column/write strobes, clock enable, a bank select, a 12-bit address bus and a data mask. It turns them into a registered command code with its target bank and address, an auto-precharge flag, a per-bank open/closed table and an error pulse for accesses to closed banks.

Clock enable drives two behaviours. When it is sampled low, the edge that follows decodes nothing (clock suspend). When a refresh is issued at the same edge that clock enable falls, the block enters self-refresh and stays there until clock enable is sampled high again. The data mask leads to two outputs. The write mask applies in the cycle the mask is sampled. The read output enable follows the mask two cycles later.

The command bus carries exactly one command per clock and cannot be stalled, so no port has a valid/ready handshake. Every output is a plain registered level that stays valid for one clock.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: With decoding enabled and chip select low, the strobes {ras_n,cas_n,we_n} decode as follows: 011 ACT, 101 READ, 100 WRITE, 010 PRE, 001 REFRESH, 000 MODE SET, 111 NOP, 110 TERMINATE. `cmd_o` codes are NOP=0, ACT=1, READ=2, WRITE=3, PRE=4, REFRESH=5, MODE SET=6, TERMINATE=7. The result is shown in the cycle after the sampling edge.
- R2: When chip select is high at a sampling edge, `cmd_o` is NOP in the following cycle, whatever the strobes are.
- R3: When `cke` is sampled low at edge N, the command sampled at edge N+1 is ignored. `cmd_o` shows NOP and the bank table does not change.
- R4: A REFRESH sampled with `cke` low at an enabled edge sets `selfref_o` from the next cycle. `selfref_o` holds while `cke` stays low and clears after the first edge that samples `cke` high. No command is decoded at any edge while in self-refresh, including that exit edge.
- R5: `bank_o` carries `ba` for decoded ACT, READ, WRITE and PRE, and is 0 for every other command.
- R6: `addr_o` carries the full 12-bit address for ACT and MODE SET, and `addr[8:0]` zero-extended for READ and WRITE. It is 0 for every other command.
- R7: `bank_open_o[b]` is set by ACT to bank b. It is cleared by PRE to bank b with `addr[10]` low, by PRE with `addr[10]` high (which clears all banks), and by READ or WRITE to bank b with `addr[10]` high (auto-precharge taken as complete once the access is accepted).
- R8: `autopre_o` equals `addr[10]` for decoded READ and WRITE, and is 0 otherwise.
- R9: `err_o` pulses for one cycle, alongside the command, when a READ or WRITE targets a bank that was closed before that command.
- R10: `wmask_o` equals the `dqm` sampled at the latest edge, so it applies to the write data of that same sampling cycle. This holds on every edge, including suspend and self-refresh.
- R11: A high `dqm` sampled at edge N drives `rd_oe_o` low during the cycle after edge N+2. The pipeline advances on every edge.
- R12: After reset, `cmd_o` is NOP, all banks are closed, `selfref_o`, `err_o`, `autopre_o` and `wmask_o` are 0, `rd_oe_o` is 1, and `bank_o` and `addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row/column address; bit 10 is the precharge option |
| dqm | input | 1 | Data mask |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 2 | Target bank |
| addr_o | output | 12 | Row or column address |
| autopre_o | output | 1 | Auto-precharge requested by this access |
| bank_open_o | output | 4 | Per-bank open status |
| err_o | output | 1 | Access to a closed bank |
| selfref_o | output | 1 | In self-refresh |
| wmask_o | output | 1 | Drop this cycle's write data |
| rd_oe_o | output | 1 | Read output enable after mask latency |

## Verification
The bench targets several corner cases, each tied to a specific wrong design. Precharge-all against single-bank precharge catches a design that ignores the bit-10 overload: it would leave banks open or close the wrong one. A write with auto-precharge must close only its own bank, and a later read to that bank must raise the error. Suspend and self-refresh sequences carry command strobes on the edges that must be ignored, so a decoder that listens one cycle too early or too late opens banks it should not. A sparse mask pattern exposes an off-by-one in the read mask latency, because isolated disabled cycles then land in the wrong slot.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  // Output-disable latency of the read mask, in clocks after the write-mask slot.
  localparam int RD_MASK_LAT = 2;

  typedef enum logic [2:0] {
    C_NOP   = 3'd0,
    C_ACT   = 3'd1,
    C_READ  = 3'd2,
    C_WRITE = 3'd3,
    C_PRE   = 3'd4,
    C_REF   = 3'd5,
    C_MRS   = 3'd6,
    C_TERM  = 3'd7
  } cmd_e;
endpackage

// File: rtl/sdcmd_strobe_dec.sv
module sdcmd_strobe_dec
  import sdcmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_n) begin
      cmd_o = C_NOP;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd_o = C_ACT;
        3'b101:  cmd_o = C_READ;
        3'b100:  cmd_o = C_WRITE;
        3'b010:  cmd_o = C_PRE;
        3'b001:  cmd_o = C_REF;
        3'b000:  cmd_o = C_MRS;
        3'b110:  cmd_o = C_TERM;
        default: cmd_o = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_bank_tbl.sv
module sdcmd_bank_tbl
  import sdcmd_pkg::*;
#(
  parameter int BANKS = 4,
  localparam int BA_W = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic             ap_i,
  output logic [BANKS-1:0] open_o,
  output logic             closed_hit_o
);
  logic is_rw;
  assign is_rw        = (cmd_i == C_READ) || (cmd_i == C_WRITE);
  assign closed_hit_o = is_rw && !open_o[ba_i];

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    logic hit, set_b, clr_b;
    assign hit   = (ba_i == BA_W'(i));
    assign set_b = (cmd_i == C_ACT) && hit;
    assign clr_b = ((cmd_i == C_PRE) && (ap_i || hit)) || (is_rw && ap_i && hit);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     open_o[i] <= 1'b0;
      else if (set_b) open_o[i] <= 1'b1;
      else if (clr_b) open_o[i] <= 1'b0;
    end
  end

  // R7: precharge with the all-banks option leaves every bank closed
  p_pre_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == C_PRE && ap_i) |=> (open_o == '0));

  // R7: activate opens the addressed bank
  p_act_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == C_ACT) |=> open_o[$past(ba_i)]);
endmodule

// File: rtl/sdcmd_mask_pipe.sv
module sdcmd_mask_pipe #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dqm_i,
  output logic wmask_o,
  output logic rd_oe_o
);
  logic [LAT:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= 1'b0;
    else        st[0] <= dqm_i;
  end

  for (genvar i = 1; i <= LAT; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= 1'b0;
      else        st[i] <= st[i-1];
    end
  end

  assign wmask_o = st[0];
  assign rd_oe_o = !st[LAT];
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdcmd_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int BANKS  = 4,
  parameter int AP_BIT = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [$clog2(BANKS)-1:0]   ba,
  input  logic [ROW_W-1:0]           addr,
  input  logic                       dqm,
  output logic [2:0]                 cmd_o,
  output logic [$clog2(BANKS)-1:0]   bank_o,
  output logic [ROW_W-1:0]           addr_o,
  output logic                       autopre_o,
  output logic [BANKS-1:0]           bank_open_o,
  output logic                       err_o,
  output logic                       selfref_o,
  output logic                       wmask_o,
  output logic                       rd_oe_o
);
  localparam int BA_W = $clog2(BANKS);

  cmd_e raw_cmd, eff_cmd, cmd_q;
  logic cke_q, sref_q, accept, sref_enter, is_rw, has_bank, closed_hit;
  logic [BA_W-1:0]  bank_q;
  logic [ROW_W-1:0] addr_q;
  logic ap_q, err_q;

  sdcmd_strobe_dec u_dec (
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .cmd_o (raw_cmd)
  );

  // A command is taken only if the previous edge saw cke high and no self-refresh.
  assign accept     = cke_q && !sref_q;
  assign eff_cmd    = accept ? raw_cmd : C_NOP;
  assign sref_enter = accept && (raw_cmd == C_REF) && !cke;
  assign is_rw      = (eff_cmd == C_READ) || (eff_cmd == C_WRITE);
  assign has_bank   = is_rw || (eff_cmd == C_ACT) || (eff_cmd == C_PRE);

  sdcmd_bank_tbl #(.BANKS(BANKS)) u_banks (
    .clk (clk), .rst_n (rst_n), .cmd_i (eff_cmd), .ba_i (ba),
    .ap_i (addr[AP_BIT]), .open_o (bank_open_o), .closed_hit_o (closed_hit)
  );

  sdcmd_mask_pipe #(.LAT(RD_MASK_LAT)) u_mask (
    .clk (clk), .rst_n (rst_n), .dqm_i (dqm), .wmask_o (wmask_o), .rd_oe_o (rd_oe_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b1;
      sref_q <= 1'b0;
      cmd_q  <= C_NOP;
      bank_q <= '0;
      addr_q <= '0;
      ap_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cke_q <= cke;
      if (sref_q) begin
        if (cke) sref_q <= 1'b0;
      end else if (sref_enter) begin
        sref_q <= 1'b1;
      end
      cmd_q  <= eff_cmd;
      bank_q <= has_bank ? ba : '0;
      case (eff_cmd)
        C_ACT, C_MRS:    addr_q <= addr;
        C_READ, C_WRITE: addr_q <= ROW_W'(addr[COL_W-1:0]);
        default:         addr_q <= '0;
      endcase
      ap_q  <= is_rw && addr[AP_BIT];
      err_q <= closed_hit;
    end
  end

  assign cmd_o     = cmd_q;
  assign bank_o    = bank_q;
  assign addr_o    = addr_q;
  assign autopre_o = ap_q;
  assign err_o     = err_q;
  assign selfref_o = sref_q;

  // Edges seen since reset, saturating; used only to guard $past in the checks.
  logic [1:0] edges_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              edges_q <= 2'd0;
    else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
  end

  // R2: deselected edge yields NOP
  p_cs_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q != 2'd0 && $past(cs_n)) |-> (cmd_o == C_NOP));

  // R3: cke low suspends decoding at the following edge
  p_suspend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q >= 2'd2 && !$past(cke, 2)) |-> (cmd_o == C_NOP));

  // R4: self-refresh persists while cke stays low
  p_sref_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (selfref_o && !cke) |=> selfref_o);

  // R4: nothing is decoded while in self-refresh
  p_sref_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    selfref_o |=> (cmd_o == C_NOP));

  // R9: error only accompanies an access
  p_err_rw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (cmd_o == C_READ || cmd_o == C_WRITE));

  // R11: read enable trails the write mask by two cycles
  p_rdoe_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q == 2'd3) |-> (rd_oe_o == !$past(wmask_o, 2)));
endmodule

// File: tb/sim_sdram_cmd_decoder.sv
module sim_sdram_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b0;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [2:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [11:0] addr_o;
  logic        autopre_o, err_o, selfref_o, wmask_o, rd_oe_o;
  logic [3:0]  bank_open_o;

  always #2 clk = ~clk; // 250 MHz

  sdram_cmd_decoder u0 (
    .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr), .dqm (dqm),
    .cmd_o (cmd_o), .bank_o (bank_o), .addr_o (addr_o), .autopre_o (autopre_o),
    .bank_open_o (bank_open_o), .err_o (err_o), .selfref_o (selfref_o),
    .wmask_o (wmask_o), .rd_oe_o (rd_oe_o)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // Reference model state and expected outputs
  int m_open[4] = '{0, 0, 0, 0};
  int m_sref = 0, m_cke_q = 1;
  int m_hist[2] = '{0, 0};
  int e_cmd = 0, e_bank = 0, e_addr = 0, e_ap = 0, e_err = 0;
  int e_sref = 0, e_wmask = 0, e_rdoe = 1, e_why = 0; // why: 0 reset,1 decode,2 cs,3 suspend,4 sref

  function automatic int lookup(logic r, logic c, logic w);
    case ({r, c, w})
      3'b011: return 1; 3'b101: return 2; 3'b100: return 3; 3'b010: return 4;
      3'b001: return 5; 3'b000: return 6; 3'b110: return 7; default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = '{0, 0, 0, 0}; m_sref = 0; m_cke_q = 1; m_hist = '{0, 0};
      e_cmd = 0; e_bank = 0; e_addr = 0; e_ap = 0; e_err = 0;
      e_sref = 0; e_wmask = 0; e_rdoe = 1; e_why = 0;
    end else begin
      int c;
      c = 0;
      if (m_sref != 0) begin
        e_why = 4;
        if (cke) m_sref = 0;
      end else if (m_cke_q == 0) begin
        e_why = 3;
      end else if (cs_n) begin
        e_why = 2;
      end else begin
        e_why = 1;
        c = lookup(ras_n, cas_n, we_n);
        if (c == 5 && !cke) m_sref = 1;
      end
      m_cke_q = cke;
      e_cmd  = c;
      e_bank = (c >= 1 && c <= 4) ? int'(ba) : 0;
      e_addr = (c == 1 || c == 6) ? int'(addr) : ((c == 2 || c == 3) ? int'(addr[8:0]) : 0);
      e_ap   = (c == 2 || c == 3) ? int'(addr[10]) : 0;
      e_err  = ((c == 2 || c == 3) && m_open[ba] == 0) ? 1 : 0;
      if (c == 1) m_open[ba] = 1;
      if (c == 4 && addr[10]) m_open = '{0, 0, 0, 0};
      if (c == 4 && !addr[10]) m_open[ba] = 0;
      if ((c == 2 || c == 3) && addr[10]) m_open[ba] = 0;
      e_sref  = m_sref;
      e_wmask = int'(dqm);
      e_rdoe  = (m_hist[1] != 0) ? 0 : 1;
      m_hist[1] = m_hist[0];
      m_hist[0] = int'(dqm);
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    string ct;
    bit rs;
    rs = (e_why == 0);
    case (e_why)
      0: ct = "R12"; 1: ct = "R1"; 2: ct = "R2"; 3: ct = "R3"; default: ct = "R4";
    endcase
    chk(ct, "cmd_o", int'(cmd_o), e_cmd);
    chk(rs ? "R12" : "R5", "bank_o", int'(bank_o), e_bank);
    chk(rs ? "R12" : "R6", "addr_o", int'(addr_o), e_addr);
    chk(rs ? "R12" : "R8", "autopre_o", int'(autopre_o), e_ap);
    chk(rs ? "R12" : "R7", "bank_open_o", int'(bank_open_o),
        m_open[0] + 2 * m_open[1] + 4 * m_open[2] + 8 * m_open[3]);
    chk(rs ? "R12" : "R9", "err_o", int'(err_o), e_err);
    chk(rs ? "R12" : "R4", "selfref_o", int'(selfref_o), e_sref);
    chk(rs ? "R12" : "R10", "wmask_o", int'(wmask_o), e_wmask);
    chk(rs ? "R12" : "R11", "rd_oe_o", int'(rd_oe_o), e_rdoe);
  endtask

  // Compare the previous edge's result, then drive the next sample.
  task automatic step(logic k, logic cs, logic [2:0] rcw, logic [1:0] b, logic [11:0] a, logic m);
    @(negedge clk);
    compare();
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a; dqm = m;
  endtask

  localparam logic [2:0] S_ACT = 3'b011, S_RD = 3'b101, S_WR = 3'b100, S_PRE = 3'b010,
                         S_REF = 3'b001, S_MRS = 3'b000, S_NOP = 3'b111, S_TRM = 3'b110;

  initial begin
    repeat (3) begin @(negedge clk); compare(); end   // R12 reset state
    rst_n = 1'b1;
    step(1, 0, S_NOP, 0, 0, 0);
    step(1, 0, S_RD,  2, 12'h010, 0);          // R9 read to closed bank
    step(1, 0, S_ACT, 1, 12'hABC, 0);          // R1 R6 row
    step(1, 0, S_RD,  1, 12'h3F5, 0);          // R6 column, R8 ap low
    step(1, 0, S_WR,  1, 12'h4A7, 1);          // R8 ap high, R7 closes bank 1, R10 mask
    step(1, 0, S_RD,  1, 12'h001, 0);          // R9 bank 1 now closed
    step(1, 0, S_ACT, 0, 12'h111, 0);
    step(1, 0, S_ACT, 2, 12'h222, 0);
    step(1, 0, S_ACT, 3, 12'h333, 1);
    step(1, 0, S_PRE, 2, 12'h000, 0);          // R7 single bank
    step(1, 0, S_PRE, 1, 12'h400, 0);          // R7 all banks
    step(1, 1, S_ACT, 0, 12'h555, 0);          // R2 deselected
    step(1, 0, S_MRS, 0, 12'h237, 1);          // R6 mode set address
    step(1, 0, S_TRM, 0, 12'h000, 0);
    step(0, 0, S_NOP, 0, 0, 0);                // R3 cke low
    step(1, 0, S_ACT, 3, 12'h0F0, 0);          // R3 ignored
    step(1, 0, S_ACT, 3, 12'h0F1, 0);
    step(0, 0, S_REF, 0, 0, 0);                // R4 enter self-refresh
    step(0, 0, S_ACT, 0, 12'h001, 1);          // ignored
    step(0, 0, S_PRE, 0, 12'h400, 0);          // ignored
    step(1, 0, S_ACT, 1, 12'h002, 0);          // R4 exit edge, ignored
    step(1, 0, S_ACT, 1, 12'h003, 1);          // decoded again
    step(1, 0, S_REF, 0, 0, 0);                // plain refresh
    step(1, 0, S_NOP, 0, 0, 1);                // R11 sparse mask pattern
    step(1, 0, S_NOP, 0, 0, 0);
    step(1, 0, S_NOP, 0, 0, 0);
    step(1, 0, S_NOP, 0, 0, 1);
    step(1, 0, S_NOP, 0, 0, 1);
    step(1, 0, S_NOP, 0, 0, 0);
    step(1, 0, S_NOP, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, ($urandom % 6) == 0, 3'($urandom), 2'($urandom),
           12'($urandom), ($urandom % 3) == 0);
    end
    step(1, 0, S_NOP, 0, 0, 0);
    @(negedge clk); compare();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule